// File: doc/BRIEF.md
# Q15 Saturating Multiply-Accumulate Unit

This block is a fixed-point arithmetic stage for Q15 samples and a Q31 accumulator, as used in speech and audio filter loops. Each transaction carries an opcode, two signed 16-bit operands and a signed 32-bit accumulator value. The block produces a registered 32-bit (wide) result, a 16-bit (narrow) result and an overflow flag. The flag is raised whenever a saturation clamp changed the outcome.

The supported operations are the doubled fractional product, multiply-accumulate and multiply-subtract into the accumulator, saturating 32-bit add and subtract, the 16-bit fractional product with and without rounding, and rounding of the accumulator to 16 bits. For operations whose natural result is wide, the narrow output gives the wide result rounded to its upper half. This rounding wraps and does not saturate. For operations whose natural result is narrow, the wide output is its sign extension.

The input and output are valid/ready streams with one output register. A transaction is accepted on a clock edge where `in_valid` and `in_ready` are both high, and the result appears on the next cycle. While `out_valid` is high and `out_ready` is low, the result holds and `in_ready` is low. When `out_ready` is high, a new transaction can be accepted in the same cycle that the old result leaves, so a continuous stream runs at one operation per cycle.

Top module: `q15_mac_unit`

## Requirements
- R1: Opcode 0 returns twice the signed product of `op_a` and `op_b` on `res_wide`. When both are 0x8000, it returns 0x7FFFFFFF and sets `res_ovf`; otherwise `res_ovf` is 0.
- R2: Opcode 3 adds `{op_a,op_b}` (op_a in bits 31:16) to `acc_in`, and opcode 4 subtracts it from `acc_in`. An out-of-range result clamps to 0x7FFFFFFF or 0x80000000 according to the sign of `acc_in`, with `res_ovf` set. Sums that cannot overflow (add with mixed signs, subtract with equal signs) never clamp.
- R3: Opcode 1 adds the R1 product to `acc_in` with the R2 add saturation, and opcode 2 subtracts it with the R2 subtract saturation. `res_ovf` is set if either the product or the accumulation clamped.
- R4: For opcodes 0 to 4, `res_narrow` equals bits 31:16 of `res_wide + 0x8000` computed modulo 2^32. This rounding never sets `res_ovf`.
- R5: Opcode 5 returns the signed product arithmetically shifted right by 15 and saturated to 16 bits. `res_ovf` is set only when a clamp happened (0x8000 times 0x8000).
- R6: Opcode 6 is opcode 5 with 0x4000 added to the product before the shift.
- R7: Opcode 7 adds 0x8000 to `acc_in` with saturation and returns bits 31:16. `res_ovf` is set when the add clamped, which yields 0x7FFF.
- R8: For opcodes 5 to 7, `res_wide` is the sign extension of `res_narrow`.
- R9: Opcodes 8 to 15 return zero on both results with `res_ovf` clear.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. A result appears the cycle after acceptance and holds unchanged while `out_valid` is high and `out_ready` is low. `out_valid` drops after a handshake with no new acceptance.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Transaction can be taken this cycle |
| opcode | input | 4 | Operation select |
| op_a | input | 16 | Signed Q15 operand A |
| op_b | input | 16 | Signed Q15 operand B |
| acc_in | input | 32 | Signed Q31 accumulator operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_wide | output | 32 | 32-bit result |
| res_narrow | output | 16 | 16-bit result |
| res_ovf | output | 1 | A saturation clamp altered the result |

## Verification
All state sits in the single output register, so any corruption shows on the ports exactly one cycle after the affected acceptance. It appears either as a wrong result word, or as a result that changes or disappears while the consumer stalls. A wrongly chosen clamp direction or a missed overflow check shows only at the range limits. For that reason, operands are placed right at the saturation boundaries, on both sides of each one. A sign-detection fault in the shared adder affects the accumulate, add, subtract and round opcodes together, so each of those is driven across its own overflow edge.

// File: rtl/q15_mac_pkg.sv
package q15_mac_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_MULW  = 4'd0,
    OP_MAC   = 4'd1,
    OP_MSU   = 4'd2,
    OP_ADDW  = 4'd3,
    OP_SUBW  = 4'd4,
    OP_MULN  = 4'd5,
    OP_MULNR = 4'd6,
    OP_RNDN  = 4'd7
  } mac_op_e;

endpackage

// File: rtl/q15_clip.sv
module q15_clip #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o,
  output logic             clip_o
);
  localparam logic signed [IN_W-1:0] LIM_HI =
    {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LIM_LO =
    {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic above, below;

  always_comb begin
    above  = $signed(in_i) > LIM_HI;
    below  = $signed(in_i) < LIM_LO;
    clip_o = above | below;
    if (above)      out_o = OUT_MAX;
    else if (below) out_o = OUT_MIN;
    else            out_o = in_i[OUT_W-1:0];
  end
endmodule

// File: rtl/q15_frac_mul.sv
module q15_frac_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] wide_o,
  output logic           wide_ovf_o,
  output logic [W-1:0]   narrow_o,
  output logic           narrow_ovf_o,
  output logic [W-1:0]   narrow_rnd_o,
  output logic           narrow_rnd_ovf_o
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  NMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] WMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic signed [PW-1:0] RND_BIAS = PW'(1) << (W - 2);

  logic signed [PW-1:0] prod, prod_bias;
  logic [PW-1:0] shf [2];
  logic [W-1:0]  clipped [2];
  logic          clipped_f [2];
  logic          both_min;

  always_comb begin
    prod      = $signed(a_i) * $signed(b_i);
    prod_bias = prod + RND_BIAS;
    both_min  = (a_i == NMIN) && (b_i == NMIN);
    // Doubling overflows only for the most negative value squared.
    wide_o     = both_min ? WMAX : (prod <<< 1);
    wide_ovf_o = both_min;
    shf[0]     = prod >>> (W - 1);
    shf[1]     = prod_bias >>> (W - 1);
  end

  for (genvar g = 0; g < 2; g++) begin : g_clip
    q15_clip #(.IN_W(PW), .OUT_W(W)) u_clip (
      .in_i   (shf[g]),
      .out_o  (clipped[g]),
      .clip_o (clipped_f[g])
    );
  end

  assign narrow_o         = clipped[0];
  assign narrow_ovf_o     = clipped_f[0];
  assign narrow_rnd_o     = clipped[1];
  assign narrow_rnd_ovf_o = clipped_f[1];
endmodule

// File: rtl/q15_sat_addsub.sv
module q15_sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         same_sign, sign_flip;

  always_comb begin
    raw       = sub_i ? (x_i - y_i) : (x_i + y_i);
    same_sign = x_i[W-1] == y_i[W-1];
    sign_flip = raw[W-1] != x_i[W-1];
    // Add can only overflow with like signs, subtract only with unlike ones.
    ovf_o     = sign_flip && (sub_i ? !same_sign : same_sign);
    sum_o     = ovf_o ? (x_i[W-1] ? SMIN : SMAX) : raw;
  end
endmodule

// File: rtl/q15_mac_unit.sv
module q15_mac_unit
  import q15_mac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [2*W-1:0]  acc_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*W-1:0]  res_wide,
  output logic [W-1:0]    res_narrow,
  output logic            res_ovf
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] HALF = PW'(1) << (W - 1);
  localparam logic [PW-1:0] WMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] WMIN = {1'b1, {(PW-1){1'b0}}};
  localparam logic [W-1:0]  NMAX = {1'b0, {(W-1){1'b1}}};

  logic [PW-1:0] mul_wide;
  logic          mul_wide_ovf;
  logic [W-1:0]  mul_nar, mul_nar_r;
  logic          mul_nar_ovf, mul_nar_r_ovf;

  q15_frac_mul #(.W(W)) u_mul (
    .a_i              (op_a),
    .b_i              (op_b),
    .wide_o           (mul_wide),
    .wide_ovf_o       (mul_wide_ovf),
    .narrow_o         (mul_nar),
    .narrow_ovf_o     (mul_nar_ovf),
    .narrow_rnd_o     (mul_nar_r),
    .narrow_rnd_ovf_o (mul_nar_r_ovf)
  );

  logic [PW-1:0] add_y, add_sum;
  logic          add_sub, add_ovf;

  // One saturating adder serves accumulate, add, subtract and round.
  always_comb begin
    add_sub = (opcode == OP_MSU) || (opcode == OP_SUBW);
    case (opcode)
      OP_MAC, OP_MSU:   add_y = mul_wide;
      OP_ADDW, OP_SUBW: add_y = {op_a, op_b};
      OP_RNDN:          add_y = HALF;
      default:          add_y = '0;
    endcase
  end

  q15_sat_addsub #(.W(PW)) u_add (
    .x_i   (acc_in),
    .y_i   (add_y),
    .sub_i (add_sub),
    .sum_o (add_sum),
    .ovf_o (add_ovf)
  );

  logic [PW-1:0] w_d;
  logic [W-1:0]  n_d;
  logic          f_d;
  logic          wide_kind, narrow_kind;

  always_comb begin
    w_d = '0;
    n_d = '0;
    f_d = 1'b0;
    wide_kind   = 1'b0;
    narrow_kind = 1'b0;
    case (opcode)
      OP_MULW: begin
        w_d = mul_wide; f_d = mul_wide_ovf; wide_kind = 1'b1;
      end
      OP_MAC, OP_MSU: begin
        w_d = add_sum; f_d = add_ovf | mul_wide_ovf; wide_kind = 1'b1;
      end
      OP_ADDW, OP_SUBW: begin
        w_d = add_sum; f_d = add_ovf; wide_kind = 1'b1;
      end
      OP_MULN: begin
        n_d = mul_nar; f_d = mul_nar_ovf; narrow_kind = 1'b1;
      end
      OP_MULNR: begin
        n_d = mul_nar_r; f_d = mul_nar_r_ovf; narrow_kind = 1'b1;
      end
      OP_RNDN: begin
        n_d = add_sum[PW-1:W]; f_d = add_ovf; narrow_kind = 1'b1;
      end
      default: ;
    endcase
    // Wrapping round of the wide result: carry in from the top fraction bit.
    if (wide_kind)   n_d = w_d[PW-1:W] + {{(W-1){1'b0}}, w_d[W-1]};
    if (narrow_kind) w_d = {{W{n_d[W-1]}}, n_d};
  end

  logic            vld_q, ovf_q;
  logic [PW-1:0]   wide_q;
  logic [W-1:0]    nar_q;
  logic [OPC_W-1:0] op_q;
  logic            accept;

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wide_q <= '0;
      nar_q  <= '0;
      op_q   <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      ovf_q  <= f_d;
      wide_q <= w_d;
      nar_q  <= n_d;
      op_q   <= opcode;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign res_wide   = wide_q;
  assign res_narrow = nar_q;
  assign res_ovf    = ovf_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(wide_q) && $stable(nar_q) && $stable(ovf_q))); // R10

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (opcode > OP_RNDN)) |=> (wide_q == '0 && nar_q == '0 && !ovf_q)); // R9

  AST_MULW_NO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == OP_MULW) |=> (wide_q != WMIN)); // R1

  AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && ovf_q && (op_q == OP_ADDW || op_q == OP_SUBW)) |-> (wide_q == WMAX || wide_q == WMIN)); // R2

  AST_ROUND_CLAMP_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && ovf_q && op_q == OP_RNDN) |-> (nar_q == NMAX)); // R7
endmodule

// File: tb/q15_mac_unit_test.sv
module q15_mac_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  opcode = '0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [31:0] acc_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res_wide;
  logic [15:0] res_narrow;
  logic        res_ovf;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  q15_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_wide(res_wide), .res_narrow(res_narrow), .res_ovf(res_ovf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void sat32(input longint v, output logic [31:0] r, output logic f);
    f = 1'b0;
    if (v > 64'sd2147483647)       begin r = 32'h7FFFFFFF; f = 1'b1; end
    else if (v < -64'sd2147483648) begin r = 32'h80000000; f = 1'b1; end
    else r = v[31:0];
  endfunction

  function automatic void sat16(input longint v, output logic [15:0] r, output logic f);
    f = 1'b0;
    if (v > 64'sd32767)       begin r = 16'h7FFF; f = 1'b1; end
    else if (v < -64'sd32768) begin r = 16'h8000; f = 1'b1; end
    else r = v[15:0];
  endfunction

  // Independent model of the requirements.
  function automatic void model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                                input logic [31:0] acc, output logic [31:0] w,
                                output logic [15:0] n, output logic f);
    longint p, m, s, av;
    logic mf, sf;
    logic [31:0] t;
    p  = longint'($signed(a)) * longint'($signed(b));
    av = longint'($signed(acc));
    if (p == 64'sd1073741824) begin m = 64'sd2147483647; mf = 1'b1; end
    else begin m = 2 * p; mf = 1'b0; end
    w = '0; n = '0; f = 1'b0;
    case (op)
      4'd0: begin w = m[31:0]; f = mf; end
      4'd1: begin sat32(av + m, w, sf); f = mf | sf; end
      4'd2: begin sat32(av - m, w, sf); f = mf | sf; end
      4'd3: begin sat32(av + longint'($signed({a, b})), w, f); end
      4'd4: begin sat32(av - longint'($signed({a, b})), w, f); end
      4'd5: begin s = p >>> 15; sat16(s, n, f); end
      4'd6: begin s = (p + 64'sd16384) >>> 15; sat16(s, n, f); end
      4'd7: begin sat32(av + 64'sd32768, t, f); n = t[31:16]; end
      default: ;
    endcase
    if (op <= 4'd4) begin t = w + 32'h8000; n = t[31:16]; end
    else if (op <= 4'd7) w = {{16{n[15]}}, n};
  endfunction

  task automatic run_op(input string req, input logic [3:0] op, input logic [15:0] a,
                        input logic [15:0] b, input logic [31:0] acc);
    logic [31:0] ew; logic [15:0] en; logic ef;
    model(op, a, b, acc, ew, en, ef);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; acc_in = acc; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "res_wide", res_wide, ew);
    chk(req, "res_narrow", 32'(res_narrow), 32'(en));
    chk(req, "res_ovf", 32'(res_ovf), 32'(ef));
  endtask

  task automatic test_reset();
    chk("R11", "out_valid", 32'(out_valid), 32'd0);
    chk("R11", "in_ready", 32'(in_ready), 32'd1);
    chk("R11", "res_wide", res_wide, 32'd0);
    chk("R11", "res_narrow", 32'(res_narrow), 32'd0);
    chk("R11", "res_ovf", 32'(res_ovf), 32'd0);
  endtask

  task automatic test_mul_wide();
    run_op("R1", 4'd0, 16'h8000, 16'h8000, 32'h0);
    chk("R1", "min squared", res_wide, 32'h7FFFFFFF);
    run_op("R1", 4'd0, 16'h4000, 16'h4000, 32'h0);
    chk("R1", "half squared", res_wide, 32'h20000000);
    run_op("R1", 4'd0, 16'h8000, 16'h7FFF, 32'h0);
    run_op("R1", 4'd0, 16'hFFFF, 16'h0003, 32'h0);
  endtask

  task automatic test_add_sub();
    run_op("R2", 4'd3, 16'h0000, 16'h0001, 32'h7FFFFFFF);
    chk("R2", "pos clamp", res_wide, 32'h7FFFFFFF);
    run_op("R2", 4'd3, 16'hFFFF, 16'hFFFF, 32'h80000000);
    chk("R2", "neg clamp", res_wide, 32'h80000000);
    run_op("R2", 4'd3, 16'h8000, 16'h0000, 32'h7FFFFFFF);
    run_op("R2", 4'd4, 16'h0000, 16'h0001, 32'h80000000);
    run_op("R2", 4'd4, 16'hFFFF, 16'hFFFF, 32'h7FFFFFFF);
    run_op("R2", 4'd4, 16'h7FFF, 16'hFFFF, 32'h7FFFFFFF);
    run_op("R2", 4'd4, 16'h1234, 16'h5678, 32'h00100000);
  endtask

  task automatic test_mac_msu();
    run_op("R3", 4'd1, 16'h4000, 16'h4000, 32'h10000000);
    run_op("R3", 4'd1, 16'h8000, 16'h8000, 32'h00000000);
    run_op("R3", 4'd1, 16'h8000, 16'h8000, 32'hF0000000);
    run_op("R3", 4'd1, 16'h7FFF, 16'h7FFF, 32'h7F000000);
    run_op("R3", 4'd2, 16'h7FFF, 16'h7FFF, 32'h80001000);
    run_op("R3", 4'd2, 16'h8000, 16'h8000, 32'h00000005);
    run_op("R3", 4'd2, 16'h0100, 16'hFF00, 32'h00000000);
  endtask

  task automatic test_wide_round();
    run_op("R4", 4'd3, 16'h0000, 16'h0000, 32'h7FFFFFFF);
    chk("R4", "wrap round", 32'(res_narrow), 32'h8000);
    chk("R4", "no flag", 32'(res_ovf), 32'd0);
    run_op("R4", 4'd3, 16'h0000, 16'h7FFF, 32'h00010000);
    run_op("R4", 4'd3, 16'h0000, 16'h8000, 32'h00010000);
  endtask

  task automatic test_mul_narrow();
    run_op("R5", 4'd5, 16'h8000, 16'h8000, 32'h0);
    chk("R5", "clamp", 32'(res_narrow), 32'h7FFF);
    run_op("R5", 4'd5, 16'hC000, 16'h4000, 32'h0);
    run_op("R5", 4'd5, 16'hFFFF, 16'h0001, 32'h0);
    chk("R5", "floor", 32'(res_narrow), 32'hFFFF);
    chk("R8", "sext", res_wide, 32'hFFFFFFFF);
    run_op("R6", 4'd6, 16'hFFFF, 16'h0001, 32'h0);
    chk("R6", "rounded", 32'(res_narrow), 32'h0000);
    run_op("R6", 4'd6, 16'h8000, 16'h8000, 32'h0);
    run_op("R6", 4'd6, 16'h0003, 16'h2AAB, 32'h0);
  endtask

  task automatic test_round();
    run_op("R7", 4'd7, 16'h0, 16'h0, 32'h7FFF8000);
    chk("R7", "sat", 32'(res_narrow), 32'h7FFF);
    run_op("R7", 4'd7, 16'h0, 16'h0, 32'h7FFF7FFF);
    run_op("R7", 4'd7, 16'h0, 16'h0, 32'hFFFF8000);
    run_op("R8", 4'd7, 16'h0, 16'h0, 32'h80000000);
    chk("R8", "sext", res_wide, 32'hFFFF8000);
  endtask

  task automatic test_unused();
    for (int op = 8; op < 16; op++) begin
      run_op("R9", 4'(op), 16'h8000, 16'h8000, 32'h7FFFFFFF);
    end
  endtask

  task automatic test_backpressure();
    logic [31:0] ew; logic [15:0] en; logic ef;
    @(negedge clk);
    out_ready = 1'b0;
    opcode = 4'd0; op_a = 16'h4000; op_b = 16'h2000; acc_in = '0; in_valid = 1'b1;
    @(negedge clk);
    chk("R10", "valid after accept", 32'(out_valid), 32'd1);
    chk("R10", "ready low when stalled", 32'(in_ready), 32'd0);
    opcode = 4'd3; op_a = 16'h0000; op_b = 16'h0005; acc_in = 32'h00000010;
    @(negedge clk);
    chk("R10", "held result", res_wide, 32'h10000000);
    chk("R10", "still valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    #1;
    chk("R10", "ready with consumer", 32'(in_ready), 32'd1);
    model(4'd3, 16'h0000, 16'h0005, 32'h00000010, ew, en, ef);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "next result", res_wide, ew);
    chk("R10", "next valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R10", "drain", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_mul_wide();
    test_add_sub();
    test_mac_msu();
    test_wide_round();
    test_mul_narrow();
    test_round();
    test_unused();
    test_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule